// File: doc/BRIEF.md
# Channel Adapter Control and Status Register Unit

This block holds the host-visible register state of a disk-channel adapter: a configuration word, a control word, a status word, a 17-bit transfer virtual address and a 16-bit byte count. Every host access carries a 12-bit longword address. The top two bits of that address pick one of three spaces. The internal space holds the adapter's own registers. The external space forwards the access to one of eight attached drives through a simple request/response port. The map space forwards it to a map store kept outside the block.

The unit keeps the transfer-busy flag, which is set when a drive is told to begin a data transfer. It folds error reports into completion and abort, refuses programming mistakes made while a transfer runs, and drives one interrupt request line. A data-movement engine outside the block reports completion, attention and error conditions through a set-vector input. Read data comes back one cycle after the access.

Top module: `chan_csr_unit`

## Requirements
- R1: Address bits 11:10 pick the space: 0 internal (register offset in bits 9:2: 0 configuration, 1 control, 2 status, 3 virtual address, 4 byte count), 1 external (drive number in bits 9:7, drive register in bits 6:2), 2 map (entry index in bits 9:2, write data masked to 0x801FFFFF). A read of space 3 returns zero.
- R2: An access whose address bits 1:0 are non-zero, or that is not longword sized, changes no state and returns no read data. Instead, err_confirm is high for the cycle after it.
- R3: Status bit 31 (busy) cannot be written. Writing ones to status bits in mask 0x608F7FFF clears those bits, and a reset leaves the status word at zero.
- R4: Whenever any status bit 11:0 is set, bits 13 (done) and 12 (aborted) are set along with it. Setting bit 12 or bit 13 clears busy.
- R5: irq rises when a newly set status bit lies in mask 0x000F7000, interrupt enable (control bit 2) was already set, and busy is clear after the update. It stays low while busy.
- R6: A control write with bit 2 at zero drops any pending irq in the same cycle.
- R7: A control write with bit 0 set first resets configuration, status, address, count and enable. The rest of the same write then applies with busy already clear.
- R8: Control bit 1 written while busy sets status bit 12. Control bit 3 written while busy is not stored and sets status bit 19 (programming error).
- R9: A virtual address or byte count write while busy sets status bit 19 and leaves the register as it was.
- R10: An external write to drive register 0 with data bit 0 set and data bits 5:0 at or above 0x28 starts a transfer. If the adapter is idle, the write reaches the drive, busy is set and all bits of mask 0x608F7FFF are cleared. If busy, the write does not reach the drive and bit 19 is set.
- R11: A byte-count read returns the count in both halves. A configuration read returns 0x20 with the power flags in bits 23:22. The power flags are set by pwr_set and cleared by writing ones to them.
- R12: An external read returns the drive's 16 bits in bits 15:0 and status bits 31:16 in the upper half. A non-existent-drive response sets status bit 18, and that bit already shows in the returned upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_long | input | 1 | Access is longword sized |
| acc_addr | input | 12 | Host byte address |
| acc_wdata | input | 32 | Host write data |
| rd_valid | output | 1 | Read data valid (one cycle after access) |
| rd_data | output | 32 | Read data |
| err_confirm | output | 1 | Rejected access flag |
| evt_set | input | 32 | Status bits raised by the data mover |
| pwr_set | input | 2 | Raise power-down / power-up flags |
| drv_req | output | 1 | Drive register access |
| drv_we | output | 1 | Drive access is a write |
| drv_num | output | 3 | Drive number |
| drv_reg | output | 5 | Drive register offset |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 16 | Drive read data (same cycle) |
| drv_nxd | input | 1 | Addressed drive does not exist |
| map_req | output | 1 | Map entry access |
| map_we | output | 1 | Map access is a write |
| map_idx | output | 8 | Map entry index |
| map_wdata | output | 32 | Masked map write data |
| map_rdata | input | 32 | Map entry read data (same cycle) |
| irq | output | 1 | Interrupt request |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
The bench aims at the ordering corners. An abort issued while the enable bit is being written on must not interrupt, because the enable seen is the old one. An init combined with a maintenance write during a transfer must be accepted, because init clears busy first. A start code just below 0x28 must not start a transfer. A second start during a transfer must never reach the drive. A design that checked the new enable would raise a spurious interrupt. A design that tested busy before applying init would flag a programming error. A design that let the repeated start through would restart the drive in the middle of a transfer. The bench also checks that the non-existent-drive bit already appears in the upper half of the read that caused it, and that attention raised during a transfer stays silent.

// File: rtl/chan_csr_pkg.sv
package chan_csr_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int VA_W     = 17;
    localparam int BC_W     = 16;
    localparam int DRV_W    = 16;
    localparam int CTL_W    = 4;
    localparam int PWR_W    = 2;

    localparam logic [DATA_W-1:0] STS_CLEARABLE = 32'h608F_7FFF;
    localparam logic [DATA_W-1:0] STS_VISIBLE   = 32'hE08F_7FFF;
    localparam logic [DATA_W-1:0] STS_FATAL     = 32'h0000_0FFF;
    localparam logic [DATA_W-1:0] STS_NOTIFY    = 32'h000F_7000;
    localparam logic [DATA_W-1:0] MAP_KEEP      = 32'h801F_FFFF;
    localparam logic [DATA_W-1:0] CFG_ID        = 32'h0000_0020;

    localparam int B_BUSY  = 31;
    localparam int B_PROG  = 19;
    localparam int B_NODRV = 18;
    localparam int B_DONE  = 13;
    localparam int B_ABRT  = 12;
    localparam int B_PWRLO = 22;

    localparam int C_INIT  = 0;
    localparam int C_STOP  = 1;
    localparam int C_IEN   = 2;
    localparam int C_MAINT = 3;

    localparam logic [5:0] START_MIN = 6'h28;

    typedef enum logic [1:0] {
        SPC_LOCAL = 2'd0,
        SPC_DRIVE = 2'd1,
        SPC_MAP   = 2'd2,
        SPC_VOID  = 2'd3
    } space_e;

    typedef struct packed {
        logic [DATA_W-1:0] sts;
        logic [CTL_W-1:0]  ctl;
        logic [PWR_W-1:0]  pwr;
        logic [VA_W-1:0]   va;
        logic [BC_W-1:0]   bc;
        logic [DATA_W-1:0] rdat;
        logic              rvld;
        logic              errc;
    } csr_state_t;

endpackage

// File: rtl/chan_csr_decode.sv
module chan_csr_decode
    import chan_csr_pkg::*;
(
    input  logic              valid,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] addr,
    output logic              bad,
    output space_e            space,
    output logic [7:0]        loc_ofs,
    output logic [2:0]        drv,
    output logic [4:0]        dreg
);
    always_comb begin
        bad     = valid && ((addr[1:0] != 2'b00) || !is_long);
        space   = space_e'(addr[11:10]);
        loc_ofs = addr[9:2];
        drv     = addr[9:7];
        dreg    = addr[6:2];
    end
endmodule

// File: rtl/chan_csr_irq.sv
module chan_csr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic withdraw,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (raise)
            irq_d = 1'b1;
        if (withdraw)
            irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/chan_csr_regs.sv
module chan_csr_regs
    import chan_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              bad,
    input  space_e            space,
    input  logic [7:0]        loc_ofs,
    input  logic [4:0]        dreg,
    input  logic [DATA_W-1:0] evt_set,
    input  logic [PWR_W-1:0]  pwr_set,
    input  logic [DRV_W-1:0]  drv_rdata,
    input  logic              drv_nxd,
    input  logic [DATA_W-1:0] map_rdata,
    output logic              drv_req,
    output logic              drv_we,
    output logic              map_req,
    output logic              map_we,
    output logic              raise,
    output logic              withdraw,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_confirm,
    output logic [DATA_W-1:0] sts_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [VA_W-1:0]   va_q,
    output logic [BC_W-1:0]   bc_q
);
    csr_state_t st_d, st_q;

    logic              ok, wr, rd, start_req, start, busy, ie_seen, mnt;
    logic [DATA_W-1:0] set_v;

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        st_d.errc = bad;
        st_d.rdat = '0;
        ok        = acc_valid && !bad;
        wr        = ok && acc_write;
        rd        = ok && !acc_write;
        set_v     = evt_set & STS_CLEARABLE;
        start     = 1'b0;
        start_req = 1'b0;
        drv_req   = 1'b0;
        drv_we    = 1'b0;
        map_req   = 1'b0;
        map_we    = 1'b0;
        withdraw  = 1'b0;
        mnt       = 1'b0;

        st_d.pwr = st_q.pwr | pwr_set;

        // init first: the rest of the same write sees the cleared state
        if (wr && space == SPC_LOCAL && loc_ofs == 8'd1 && acc_wdata[C_INIT]) begin
            st_d.sts = '0;
            st_d.ctl = st_q.ctl & (CTL_W'(1) << C_MAINT);
            st_d.pwr = '0;
            st_d.va  = '0;
            st_d.bc  = '0;
        end
        busy    = st_d.sts[B_BUSY];
        ie_seen = st_d.ctl[C_IEN];

        if (ok) begin
            unique case (space)
                SPC_LOCAL: begin
                    if (wr) begin
                        unique case (loc_ofs)
                            8'd0: st_d.pwr = st_d.pwr & ~acc_wdata[B_PWRLO +: PWR_W];
                            8'd1: begin
                                if (acc_wdata[C_STOP] && busy)
                                    set_v[B_ABRT] = 1'b1;
                                mnt = acc_wdata[C_MAINT];
                                if (mnt && busy) begin
                                    set_v[B_PROG] = 1'b1;
                                    mnt = 1'b0;
                                end
                                withdraw = !acc_wdata[C_IEN];
                                st_d.ctl = {mnt, acc_wdata[C_IEN], acc_wdata[C_STOP], 1'b0};
                            end
                            8'd2: st_d.sts = st_d.sts & ~(acc_wdata & STS_CLEARABLE);
                            8'd3: begin
                                if (busy) set_v[B_PROG] = 1'b1;
                                else      st_d.va = acc_wdata[VA_W-1:0];
                            end
                            8'd4: begin
                                if (busy) set_v[B_PROG] = 1'b1;
                                else      st_d.bc = acc_wdata[BC_W-1:0];
                            end
                            default: ;
                        endcase
                    end else begin
                        st_d.rvld = 1'b1;
                        unique case (loc_ofs)
                            8'd0: st_d.rdat = (DATA_W'(st_q.pwr) << B_PWRLO) | CFG_ID;
                            8'd1: st_d.rdat = DATA_W'(st_q.ctl & ~(CTL_W'(1) << C_INIT));
                            8'd2: st_d.rdat = st_q.sts & STS_VISIBLE;
                            8'd3: st_d.rdat = DATA_W'(st_q.va);
                            8'd4: st_d.rdat = {st_q.bc, st_q.bc};
                            default: st_d.rdat = '0;
                        endcase
                    end
                end
                SPC_DRIVE: begin
                    start_req = acc_write && dreg == 5'd0 && acc_wdata[0]
                                && (acc_wdata[5:0] >= START_MIN);
                    if (start_req && busy) begin
                        set_v[B_PROG] = 1'b1;
                    end else begin
                        drv_req = 1'b1;
                        drv_we  = acc_write;
                        if (drv_nxd)
                            set_v[B_NODRV] = 1'b1;
                        else
                            start = start_req;
                    end
                    st_d.rvld = rd;
                end
                SPC_MAP: begin
                    map_req   = 1'b1;
                    map_we    = acc_write;
                    st_d.rvld = rd;
                    st_d.rdat = map_rdata & MAP_KEEP;
                end
                default: st_d.rvld = rd;
            endcase
        end

        // fold error classes into completion, then end busy
        if (|(set_v & STS_FATAL)) begin
            set_v[B_DONE] = 1'b1;
            set_v[B_ABRT] = 1'b1;
        end
        if (set_v[B_DONE] || set_v[B_ABRT])
            st_d.sts[B_BUSY] = 1'b0;
        st_d.sts = st_d.sts | set_v;
        if (start) begin
            st_d.sts         = st_d.sts & ~STS_CLEARABLE;
            st_d.sts[B_BUSY] = 1'b1;
        end

        if (rd && space == SPC_DRIVE)
            st_d.rdat = {st_d.sts[DATA_W-1:DRV_W], drv_rdata};

        raise = (|(set_v & STS_NOTIFY)) && ie_seen && !st_d.sts[B_BUSY];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_valid    = st_q.rvld;
    assign rd_data     = st_q.rdat;
    assign err_confirm = st_q.errc;
    assign sts_q       = st_q.sts;
    assign ctl_q       = st_q.ctl;
    assign va_q        = st_q.va;
    assign bc_q        = st_q.bc;
endmodule

// File: rtl/chan_csr_unit.sv
module chan_csr_unit
    import chan_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_long,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_confirm,
    input  logic [DATA_W-1:0] evt_set,
    input  logic [PWR_W-1:0]  pwr_set,
    output logic              drv_req,
    output logic              drv_we,
    output logic [2:0]        drv_num,
    output logic [4:0]        drv_reg,
    output logic [DRV_W-1:0]  drv_wdata,
    input  logic [DRV_W-1:0]  drv_rdata,
    input  logic              drv_nxd,
    output logic              map_req,
    output logic              map_we,
    output logic [7:0]        map_idx,
    output logic [DATA_W-1:0] map_wdata,
    input  logic [DATA_W-1:0] map_rdata,
    output logic              irq,
    output logic              xfer_busy
);
    logic              bad, raise, withdraw;
    space_e            space;
    logic [7:0]        loc_ofs;
    logic [DATA_W-1:0] sts_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [VA_W-1:0]   va_q;
    logic [BC_W-1:0]   bc_q;

    chan_csr_decode u_dec (
        .valid   (acc_valid),
        .is_long (acc_long),
        .addr    (acc_addr),
        .bad     (bad),
        .space   (space),
        .loc_ofs (loc_ofs),
        .drv     (drv_num),
        .dreg    (drv_reg)
    );

    chan_csr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_wdata   (acc_wdata),
        .bad         (bad),
        .space       (space),
        .loc_ofs     (loc_ofs),
        .dreg        (drv_reg),
        .evt_set     (evt_set),
        .pwr_set     (pwr_set),
        .drv_rdata   (drv_rdata),
        .drv_nxd     (drv_nxd),
        .map_rdata   (map_rdata),
        .drv_req     (drv_req),
        .drv_we      (drv_we),
        .map_req     (map_req),
        .map_we      (map_we),
        .raise       (raise),
        .withdraw    (withdraw),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .err_confirm (err_confirm),
        .sts_q       (sts_q),
        .ctl_q       (ctl_q),
        .va_q        (va_q),
        .bc_q        (bc_q)
    );

    chan_csr_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (raise),
        .withdraw (withdraw),
        .irq      (irq)
    );

    assign drv_wdata = acc_wdata[DRV_W-1:0];
    assign map_idx   = loc_ofs;
    assign map_wdata = acc_wdata & MAP_KEEP;
    assign xfer_busy = sts_q[B_BUSY];
endmodule

// File: rtl/chan_csr_chk.sv
module chan_csr_chk
    import chan_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              rd_valid,
    input logic              err_confirm,
    input logic [DATA_W-1:0] sts_q,
    input logic [CTL_W-1:0]  ctl_q,
    input logic [VA_W-1:0]   va_q,
    input logic [BC_W-1:0]   bc_q
);
    // R4
    fatal_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_q[11:0] & ~$past(sts_q[11:0]))) |-> (sts_q[B_DONE] && sts_q[B_ABRT] && !sts_q[B_BUSY]));

    // R5
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!sts_q[B_BUSY] && ctl_q[C_IEN]));

    // R6
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_q[C_IEN]);

    // R10
    start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[B_BUSY]) |-> ((sts_q & STS_CLEARABLE) == '0));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[B_BUSY] && $past(sts_q[B_BUSY])) |-> ($stable(va_q) && $stable(bc_q)));

    // R2
    reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_confirm |-> !rd_valid);
endmodule

bind chan_csr_unit chan_csr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .rd_valid    (rd_valid),
    .err_confirm (err_confirm),
    .sts_q       (sts_q),
    .ctl_q       (ctl_q),
    .va_q        (va_q),
    .bc_q        (bc_q)
);

// File: tb/chan_csr_unit_bench.sv
module chan_csr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_long = 1'b1;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid, err_confirm, irq, xfer_busy;
    logic [31:0] rd_data;
    logic [31:0] evt_set = '0;
    logic [1:0]  pwr_set = '0;
    logic        drv_req, drv_we, drv_nxd, map_req, map_we;
    logic [2:0]  drv_num;
    logic [4:0]  drv_reg;
    logic [15:0] drv_wdata, drv_rdata;
    logic [7:0]  map_idx;
    logic [31:0] map_wdata, map_rdata;

    int n_chk = 0, n_fail = 0;
    int drv_wr_cnt = 0, map_wr_cnt = 0;
    logic [15:0] last_drv_wd = '0;
    logic [7:0]  last_map_idx = '0;
    logic [31:0] last_map_wd = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    chan_csr_unit u_chan_csr_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_long(acc_long), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_confirm(err_confirm),
        .evt_set(evt_set), .pwr_set(pwr_set), .drv_req(drv_req), .drv_we(drv_we),
        .drv_num(drv_num), .drv_reg(drv_reg), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata), .drv_nxd(drv_nxd), .map_req(map_req), .map_we(map_we),
        .map_idx(map_idx), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .irq(irq), .xfer_busy(xfer_busy)
    );

    // drive and map stubs
    assign drv_rdata = {drv_num, drv_reg, 8'hA5};
    assign drv_nxd   = (drv_num == 3'd7);
    assign map_rdata = 32'h8000_0000 | {24'h0, map_idx};

    always @(posedge clk) begin
        if (drv_req && drv_we) begin
            drv_wr_cnt  <= drv_wr_cnt + 1;
            last_drv_wd <= drv_wdata;
        end
        if (map_req && map_we) begin
            map_wr_cnt   <= map_wr_cnt + 1;
            last_map_idx <= map_idx;
            last_map_wd  <= map_wdata;
        end
    end

    function automatic logic [11:0] ia(input int ofs);
        return 12'(ofs << 2);
    endfunction
    function automatic logic [11:0] ea(input int d, input int r);
        return 12'h400 | 12'(d << 7) | 12'(r << 2);
    endfunction
    function automatic logic [11:0] ma(input int idx);
        return 12'h800 | 12'(idx << 2);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2: unexpected read data %h expected none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rd_data, e, t);
            end
        end
    end

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d, input logic lng);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d; acc_long = lng;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_long = 1'b1;
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        access(1'b1, a, d, 1'b1);
    endtask
    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, a, 32'h0, 1'b1);
    endtask
    task automatic event_pulse(input logic [31:0] v);
        @(negedge clk); evt_set = v;
        @(negedge clk); evt_set = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk({31'b0, irq}, 32'h0, "R5 reset irq");
        chk({31'b0, xfer_busy}, 32'h0, "R3 reset busy");
        rd(ia(2), 32'h0, "R3 reset status");
        rd(ia(1), 32'h0, "R7 reset control");
        rd(ia(3), 32'h0, "R1 reset va");
        rd(ia(4), 32'h0, "R11 reset count");
        rd(ia(0), 32'h20, "R11 config id");

        wr(ia(3), 32'hFFFE_2345);
        rd(ia(3), 32'h0000_2345, "R1 va 17 bits");
        wr(ia(4), 32'hABCD_1234);
        rd(ia(4), 32'h1234_1234, "R11 count mirrored");

        @(negedge clk); pwr_set = 2'b11;
        @(negedge clk); pwr_set = 2'b00;
        rd(ia(0), 32'h00C0_0020, "R11 power flags");
        wr(ia(0), 32'h0040_0000);
        rd(ia(0), 32'h0080_0020, "R11 power w1c");

        access(1'b1, ia(3) | 12'h1, 32'h0, 1'b1);
        chk({31'b0, err_confirm}, 32'h1, "R2 unaligned");
        access(1'b1, ia(3), 32'h0, 1'b0);
        chk({31'b0, err_confirm}, 32'h1, "R2 short");
        access(1'b0, ia(2) | 12'h2, 32'h0, 1'b1);
        rd(ia(3), 32'h0000_2345, "R2 va untouched");

        rd(ea(2, 3), 32'h0000_43A5, "R12 drive read");
        rd(ea(7, 0), 32'h0004_E0A5, "R12 missing drive");
        rd(ia(2), 32'h0004_0000, "R12 status nodrv");
        chk({31'b0, irq}, 32'h0, "R5 no enable");

        wr(ea(1, 0), 32'h39);
        chk(32'(drv_wr_cnt), 32'd1, "R10 start reaches drive");
        chk({16'h0, last_drv_wd}, 32'h39, "R10 drive data");
        rd(ia(2), 32'h8000_0000, "R10 busy and cleared");

        wr(ia(3), 32'h1111);
        rd(ia(3), 32'h0000_2345, "R9 va refused");
        rd(ia(2), 32'h8008_0000, "R9 prog error");
        wr(ia(4), 32'h7777);
        rd(ia(4), 32'h1234_1234, "R9 count refused");
        wr(ea(1, 0), 32'h3B);
        chk(32'(drv_wr_cnt), 32'd1, "R10 repeat start dropped");
        wr(ia(1), 32'hC);
        rd(ia(1), 32'h4, "R8 maint refused");
        chk({31'b0, irq}, 32'h0, "R5 busy no irq");

        event_pulse(32'h2);
        chk({31'b0, irq}, 32'h1, "R5 irq on abort");
        rd(ia(2), 32'h0008_3002, "R4 fold");
        wr(ia(1), 32'h0);
        chk({31'b0, irq}, 32'h0, "R6 withdraw");
        wr(ia(2), 32'hFFFF_FFFF);
        rd(ia(2), 32'h0, "R3 w1c all");

        wr(ea(1, 0), 32'h39);
        wr(ia(1), 32'h6);
        rd(ia(2), 32'h0000_1000, "R8 abort while busy");
        chk({31'b0, irq}, 32'h0, "R5 old enable seen");
        rd(ia(1), 32'h6, "R8 control stored");
        event_pulse(32'h2000);
        chk({31'b0, irq}, 32'h1, "R5 done irq");

        wr(ea(1, 0), 32'h27);
        rd(ia(2), 32'h0000_3000, "R10 code below start");
        wr(ea(1, 1), 32'h39);
        rd(ia(2), 32'h0000_3000, "R10 other register");
        chk(32'(drv_wr_cnt), 32'd4, "R10 plain writes pass");

        wr(ia(1), 32'h0);
        wr(ea(1, 0), 32'h39);
        wr(ia(1), 32'h4);
        event_pulse(32'h0001_0000);
        chk({31'b0, irq}, 32'h0, "R5 attention while busy");
        rd(ia(2), 32'h8001_0000, "R5 attention latched");

        wr(ia(1), 32'h9);
        rd(ia(2), 32'h0, "R7 init clears busy");
        rd(ia(1), 32'h8, "R7 maint after init");
        rd(ia(3), 32'h0, "R7 va cleared");
        rd(ia(4), 32'h0, "R7 count cleared");
        rd(ia(0), 32'h20, "R7 config cleared");

        wr(ma(5), 32'hFFFF_FFFF);
        chk(32'(map_wr_cnt), 32'd1, "R1 map write");
        chk({24'h0, last_map_idx}, 32'h5, "R1 map index");
        chk(last_map_wd, 32'h801F_FFFF, "R1 map mask");
        rd(ma(9), 32'h8000_0009, "R1 map read");
        rd(12'hC00, 32'h0, "R1 void space");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1: actual %0d pending reads expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule